// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects 96 interrupt sources into one request line for a processor. The sources sit in three 32-bit banks: source n lives in bank n/32 at bit n%32. Every source owns a latched pending bit, an enable bit and a mask bit. A source is active when it is pending, enabled and not masked. The request output is high while any source is active. A vector register reports the winning source as its index times four.

Source 0 is driven by an external pin, and its trigger type can be programmed. Once that source is latched, it stays pending until software clears it explicitly. A vector reading of zero can therefore mean "nothing active" or "source 0 active". Software resolves the case by checking bit 0 of pending bank 0, or by checking the request line.

A protection register limits register writes to privileged bus accesses. A build parameter picks one of two placements for the enable and mask banks.

Top module: `vic_ctrl`

## Requirements
- R1: For sources 1 to 95, a high input sets the pending bit on the next clock edge. Writing 1 to a bit of a pending register (offsets 0x10, 0x14, 0x18 for banks 0 to 2) clears that bit. If the input is high in the same cycle as the clear, the set wins.
- R2: A read at offset 0x00 returns the index of the lowest-numbered active source, shifted left by two. It returns 0 when no source is active.
- R3: The `irq` output is high exactly when at least one source is active.
- R4: An enable bit of 0 keeps its source out of `irq` and out of the vector. A mask bit of 1 does the same. By default the enable banks are at 0x40/0x44/0x48 and the mask banks are at 0x50/0x54/0x58, and all of them read back what was written.
- R5: With `ALT_MAP=1`, the enable banks move to 0x20/0x24/0x28 and the mask banks move to 0x30/0x34/0x38. The default locations then read as unmapped.
- R6: Bits [1:0] of the register at 0x0c set the trigger of the external source. 0 is low level, 1 is high level, 2 is a falling edge and 3 is a rising edge. An edge is found by comparing the pin with its value one cycle earlier.
- R7: Source 0 stays pending until a write of 1 to bit 0 at offset 0x10 clears it. While it is the only active source, the vector reads 0 and `irq` is high.
- R8: Bit 0 of the register at 0x08 turns protection on. While protection is on, a write with `bus_priv` low changes no register.
- R9: Every register resets to 0. Reads at unmapped offsets, including 0x04 and 0x1c, return 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_irq | input | 1 | External pin feeding source 0 |
| src_irq | input | 95 | Active-high requests for sources 1 to 95 |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_priv | input | 1 | Marks the access as privileged |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Request line to the processor |

## Verification
The assertions assume that every input is synchronous to `clk` and is held steady across each edge. They also assume that a write lasts exactly one cycle. The bench changes its inputs just after a rising edge and checks the outputs at the falling edge, so every write pulse is confined to one cycle. In the random phase, the sources, the external pin, the trigger mode, the privilege and the protection bit all change freely. Their sequences therefore reach cases the assertions name: unprivileged writes while protection is on, and pending clears that collide with a source that is still asserted.

// File: rtl/vic_ctrl.sv
module vic_ctrl #(
  parameter int NSRC    = 96,
  parameter bit ALT_MAP = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_irq,
  input  logic [NSRC-1:1] src_irq,
  input  logic            bus_wr,
  input  logic            bus_priv,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq
);
  localparam int NB = NSRC / 32;
  localparam int IW = $clog2(NSRC);
  localparam int W_PEND = 4;
  localparam int W_EN   = ALT_MAP ? 8 : 16;
  localparam int W_MASK = ALT_MAP ? 12 : 20;

  logic [NSRC-1:0] pend_q, en_q, mask_q;
  logic            prot_q, ext_prev_q, ext_hit;
  logic [1:0]      trig_q;
  logic [IW-1:0]   vec_idx;

  wire [5:0]      word   = bus_addr[7:2];
  wire            wr_ok  = bus_wr && (!prot_q || bus_priv);
  wire [NSRC-1:0] active = pend_q & en_q & ~mask_q;
  wire [NSRC-1:0] set_v  = {src_irq, ext_hit};

  assign irq = |active;

  always_comb begin
    case (trig_q)
      2'd0:    ext_hit = !ext_irq;
      2'd1:    ext_hit = ext_irq;
      2'd2:    ext_hit = ext_prev_q && !ext_irq;
      default: ext_hit = !ext_prev_q && ext_irq;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q     <= 1'b0;
      trig_q     <= 2'd0;
      ext_prev_q <= 1'b0;
    end else begin
      ext_prev_q <= ext_irq;
      if (wr_ok && word == 6'd2) prot_q <= bus_wdata[0];
      if (wr_ok && word == 6'd3) trig_q <= bus_wdata[1:0];
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    wire [31:0] clr = (wr_ok && word == 6'(W_PEND + b)) ? bus_wdata : 32'd0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[b*32 +: 32] <= '0;
        en_q[b*32 +: 32]   <= '0;
        mask_q[b*32 +: 32] <= '0;
      end else begin
        pend_q[b*32 +: 32] <= (pend_q[b*32 +: 32] & ~clr) | set_v[b*32 +: 32];
        if (wr_ok && word == 6'(W_EN + b))   en_q[b*32 +: 32]   <= bus_wdata;
        if (wr_ok && word == 6'(W_MASK + b)) mask_q[b*32 +: 32] <= bus_wdata;
      end
    end
  end

  always_comb begin
    vec_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (active[i]) vec_idx = IW'(i);
  end

  always_comb begin
    bus_rdata = '0;
    if (word == 6'd0) bus_rdata = 32'(vec_idx) << 2;
    if (word == 6'd2) bus_rdata = {31'd0, prot_q};
    if (word == 6'd3) bus_rdata = {30'd0, trig_q};
    for (int b = 0; b < NB; b++) begin
      if (word == 6'(W_PEND + b)) bus_rdata = pend_q[b*32 +: 32];
      if (word == 6'(W_EN + b))   bus_rdata = en_q[b*32 +: 32];
      if (word == 6'(W_MASK + b)) bus_rdata = mask_q[b*32 +: 32];
    end
  end

  a_r1_src_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_irq) |=> ((pend_q[NSRC-1:1] & $past(src_irq)) == $past(src_irq)));

  a_r2_idle_vec_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (vec_idx == '0));

  a_r3_zero_vec_means_src0: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && vec_idx == '0) |-> pend_q[0]);

  a_r7_src0_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[0] && !(wr_ok && word == 6'(W_PEND) && bus_wdata[0])) |=> pend_q[0]);

  a_r8_prot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_q && bus_wr && !bus_priv) |=>
      ($stable(en_q) && $stable(mask_q) && $stable(trig_q) && $stable(prot_q)));
endmodule

// File: tb/vic_ctrl_tb.sv
module vic_ctrl_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_irq = 1'b1;
  logic [95:1] src_irq = '0;
  logic        bus_wr = 1'b0, bus_priv = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, alt_rdata;
  logic        irq, alt_irq;
  int checks = 0, fails = 0;
  bit run = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  vic_ctrl u_dut (.clk, .rst_n, .ext_irq, .src_irq, .bus_wr, .bus_priv,
    .bus_addr, .bus_wdata, .bus_rdata, .irq);
  vic_ctrl #(.ALT_MAP(1'b1)) u_alt (.clk, .rst_n, .ext_irq, .src_irq, .bus_wr,
    .bus_priv, .bus_addr, .bus_wdata, .bus_rdata(alt_rdata), .irq(alt_irq));

  // reference model, default map
  logic [95:0] m_pend, m_en, m_mask;
  logic        m_prot, m_prev;
  logic [1:0]  m_trig;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = '0; m_en = '0; m_mask = '0; m_prot = 0; m_prev = 0; m_trig = 0;
    end else begin
      bit ok, hit;
      int a;
      logic [95:0] nxt;
      ok = bus_wr && (!m_prot || bus_priv);
      a = int'(bus_addr);
      hit = (m_trig == 0) ? !ext_irq : (m_trig == 1) ? ext_irq :
            (m_trig == 2) ? (m_prev && !ext_irq) : (!m_prev && ext_irq);
      nxt = m_pend;
      for (int b = 0; b < 3; b++) begin
        if (ok && a == 16 + 4*b) nxt[b*32 +: 32] = nxt[b*32 +: 32] & ~bus_wdata;
        if (ok && a == 64 + 4*b) m_en[b*32 +: 32] = bus_wdata;
        if (ok && a == 80 + 4*b) m_mask[b*32 +: 32] = bus_wdata;
      end
      for (int i = 1; i < 96; i++) if (src_irq[i]) nxt[i] = 1'b1;
      if (hit) nxt[0] = 1'b1;
      m_pend = nxt;
      m_prev = ext_irq;
      if (ok && a == 8)  m_prot = bus_wdata[0];
      if (ok && a == 12) m_trig = bus_wdata[1:0];
    end
  end

  function automatic logic [31:0] exp_rd(int a);
    logic [95:0] act = m_pend & m_en & ~m_mask;
    if (a == 0) begin
      for (int i = 0; i < 96; i++) if (act[i]) return 32'(i * 4);
      return 0;
    end
    if (a == 8)  return {31'd0, m_prot};
    if (a == 12) return {30'd0, m_trig};
    for (int b = 0; b < 3; b++) begin
      if (a == 16 + 4*b) return m_pend[b*32 +: 32];
      if (a == 64 + 4*b) return m_en[b*32 +: 32];
      if (a == 80 + 4*b) return m_mask[b*32 +: 32];
    end
    return 0;
  endfunction

  function automatic string tag_of(int a);
    if (a == 0) return "R2";
    if (a == 8) return "R8";
    if (a == 12) return "R6";
    if (a >= 16 && a <= 24) return "R1";
    if ((a >= 64 && a <= 72) || (a >= 80 && a <= 88)) return "R4";
    return "R9";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && run) begin
    chk("R3", {31'd0, irq}, {31'd0, |(m_pend & m_en & ~m_mask)});
    chk(tag_of(int'(bus_addr)), bus_rdata, exp_rd(int'(bus_addr)));
  end

  task automatic wr(int a, logic [31:0] d, bit p = 1'b1);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = d; bus_priv = p;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_priv = 1'b0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    @(posedge clk); #1; bus_addr = 8'(a);
    @(negedge clk); chk(tag, bus_rdata, exp);
  endtask

  task automatic ext_set(bit v);
    @(posedge clk); #1; ext_irq = v;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1; run = 1'b1;
    // R9 reset and unmapped offsets
    rd(8'h10, 0, "R9"); rd(8'h40, 0, "R9"); rd(8'h08, 0, "R9");
    rd(8'h04, 0, "R9"); rd(8'h1c, 0, "R9"); chk("R9", {31'd0, irq}, 0);
    // R4 enable all
    wr(8'h40, 32'hffff_ffff); wr(8'h44, 32'hffff_ffff); wr(8'h48, 32'hffff_ffff);
    rd(8'h44, 32'hffff_ffff, "R4");
    // R1 latch of a one-cycle pulse
    @(posedge clk); #1; src_irq[5] = 1; src_irq[40] = 1; src_irq[70] = 1;
    @(posedge clk); #1; src_irq = '0;
    rd(8'h00, 5 * 4, "R2"); rd(8'h10, 32'h20, "R1"); chk("R3", {31'd0, irq}, 1);
    wr(8'h50, 32'h20);                       // R4 mask source 5
    rd(8'h00, 40 * 4, "R4");
    wr(8'h44, ~32'h100);                     // R4 disable source 40
    rd(8'h00, 70 * 4, "R4");
    wr(8'h18, 32'h40);                       // R1 clear source 70
    rd(8'h18, 0, "R1"); rd(8'h00, 0, "R2"); chk("R3", {31'd0, irq}, 0);
    // R1 set wins over a simultaneous clear
    @(posedge clk); #1; src_irq[33] = 1;
    wr(8'h14, 32'h2);
    @(posedge clk); #1; src_irq = '0;
    rd(8'h14, 32'h102, "R1");
    wr(8'h14, 32'h2); rd(8'h14, 32'h100, "R1");
    // R6/R7 rising edge on source 0
    wr(8'h0c, 3); ext_set(0); ext_set(1);
    rd(8'h00, 0, "R7"); chk("R7", {31'd0, irq}, 1);
    repeat (4) @(posedge clk);
    rd(8'h10, 32'h21, "R7");
    wr(8'h10, 1); rd(8'h10, 32'h20, "R7"); chk("R7", {31'd0, irq}, 0);
    // R6 falling edge
    wr(8'h0c, 2); ext_set(0); rd(8'h10, 32'h21, "R6");
    wr(8'h10, 1); rd(8'h10, 32'h20, "R6");
    // R6 high level re-asserts after clear
    wr(8'h0c, 1); ext_set(1); wr(8'h10, 1); rd(8'h10, 32'h21, "R6");
    ext_set(0); wr(8'h10, 1); rd(8'h10, 32'h20, "R6");
    // R6 low level
    wr(8'h0c, 0); rd(8'h10, 32'h21, "R6");
    ext_set(1); wr(8'h10, 1); rd(8'h10, 32'h20, "R6");
    // R8 protection
    wr(8'h08, 1, 1); wr(8'h40, 0, 0);
    rd(8'h40, 32'hffff_ffff, "R8");
    wr(8'h40, 32'hf, 1); rd(8'h40, 32'hf, "R8");
    wr(8'h08, 0, 0); rd(8'h08, 1, "R8");
    wr(8'h08, 0, 1); rd(8'h08, 0, "R8");
    // R5 alternate placement
    wr(8'h20, 32'ha5a5); rd(8'h20, 0, "R9"); chk("R5", alt_rdata, 32'ha5a5);
    wr(8'h34, 32'h5a); rd(8'h34, 0, "R9"); chk("R5", alt_rdata, 32'h5a);
    rd(8'h40, 32'hf, "R4"); chk("R5", alt_rdata, 0);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [95:0] r;
      int pick;
      @(posedge clk); #1;
      r = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom}
        & {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
      src_irq = r[95:1];
      ext_irq = 1'($urandom);
      pick = int'($urandom % 15);
      bus_addr = (pick < 3) ? 8'(8'h10 + 4*pick) : (pick < 6) ? 8'(8'h40 + 4*(pick-3)) :
                 (pick < 9) ? 8'(8'h50 + 4*(pick-6)) : (pick == 9) ? 8'h08 :
                 (pick == 10) ? 8'h0c : (pick == 11) ? 8'h1c : 8'h00;
      bus_wr = ($urandom % 3) == 0;
      bus_wdata = (bus_addr == 8'h08) ? 32'($urandom % 2) : $urandom;
      bus_priv = ($urandom % 4) != 0;
    end
    @(posedge clk); #1; bus_wr = 1'b0;
    repeat (2) @(negedge clk);
    run = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule